// File: doc/BRIEF.md
# Memory-card byte lane steering decoder

This block sits behind the host connector of a removable flash storage card operating in its memory-mapped mode. Every cycle it looks at the host address, at two active-low byte enables, at a space select, and at the read and write strobes. From these it decides whether an access goes to common memory or to the small attribute space. It also decides which byte of the addressed 16-bit word travels on which half of the host data bus. A 16-bit host can move whole words, a host wired for 8 bits can still reach odd bytes through the low lane, and a host can fetch only the odd byte on the high lane.

Reads are combinational. The output data and the per-lane drive enables follow the inputs in the same cycle, and each lane is driven only while the read strobe and an enable that selects that lane are active. Writes are captured while the write strobe is low and commit on the first clock edge at which the strobe is seen high again. Common-memory writes then appear on a word-wide backend port with byte enables, pulsed for one cycle. Attribute writes go to an internal store: 256 information-structure bytes at even addresses below 0x200, and a few configuration bytes at even addresses from 0x200 upward.

Top module: `mcard_lane_dec`

## Requirements
- R1: After reset, no data lane is driven, the read data is 0x0000, `cm_wr` is 0, and every configuration byte reads as 0x00.
- R2: With only the even enable asserted and address bit 0 clear, a read drives only the low lane, which carries the even byte (word bits 7:0).
- R3: With only the even enable asserted and address bit 0 set, a read drives only the low lane, which carries the odd byte (word bits 15:8).
- R4: With only the odd enable asserted, a read drives only the high lane, which carries the odd byte, whatever the value of address bit 0.
- R5: With both enables asserted, a read drives both lanes, with the even byte on bits 7:0 and the odd byte on bits 15:8.
- R6: With the read strobe high or both enables high, neither lane is driven, and a lane that is not driven reads 0x00.
- R7: Space select high routes a read to common memory with `cm_rd` high and `cm_raddr` equal to address bits 10:1. Space select low routes it to attribute space with `cm_rd` low.
- R8: A common-memory write pulses `cm_wr` for exactly one cycle, in the cycle after the first clock edge that samples the write strobe high following a low sample. `cm_wbe` bit 0 marks the even byte (`cm_wdata` 7:0) and bit 1 the odd byte (15:8). An odd byte written through the low lane with only the even enable appears in `cm_wdata` 15:8.
- R9: An attribute byte at an even address below 0x200 reads back what was written to it. An attribute read at an odd address returns 0x00, and an attribute write to an odd address changes nothing.
- R10: Configuration bytes sit at attribute addresses 0x200 + 2k for k from 0 to 3 and are writable. Attribute addresses above that range read 0x00 and ignore writes.
- R11: An attribute write never asserts `cm_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 11 | Host byte address |
| host_ce_even_n | input | 1 | Active-low even/low-lane enable |
| host_ce_odd_n | input | 1 | Active-low odd-byte enable (high lane) |
| host_regsel_n | input | 1 | High selects common memory, low selects attribute space |
| host_oe_n | input | 1 | Active-low read strobe |
| host_we_n | input | 1 | Active-low write strobe, commits on its trailing edge |
| host_wdata | input | 16 | Data from the host |
| host_rdata | output | 16 | Data to the host, undriven lanes zero |
| host_drive_lo | output | 1 | Drive enable for bits 7:0 |
| host_drive_hi | output | 1 | Drive enable for bits 15:8 |
| cm_raddr | output | 10 | Common-memory word read address |
| cm_rd | output | 1 | Common-memory read active |
| cm_rdata | input | 16 | Common-memory read word |
| cm_wr | output | 1 | Common-memory write pulse |
| cm_waddr | output | 10 | Common-memory word write address |
| cm_wbe | output | 2 | Write byte enables, bit 0 even |
| cm_wdata | output | 16 | Steered write word |

## Verification
A wrong lane decode shows up at once on a read. The drive enables or the byte placed on a lane differ in the same cycle as the bad input pattern, so each pattern in the read table catches it on the spot. A wrong write-capture state shows up one cycle after the trailing edge of the strobe. The pulse arrives early or late, is doubled, or carries wrong byte enables or data. A fault in the attribute store is seen only at the next read of the affected byte, which is why the bench reads back each attribute location right after writing it.

// File: rtl/mcard_pkg.sv
package mcard_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic lo_on;
        logic hi_on;
        logic lo_odd;
    } lane_sel_t;

    typedef struct packed {
        logic [BYTE_W-1:0] odd;
        logic [BYTE_W-1:0] even;
    } word_t;

    function automatic lane_sel_t lane_decode(input logic ce_even_n,
                                              input logic ce_odd_n,
                                              input logic a0);
        lane_sel_t s;
        s.lo_on  = !ce_even_n;
        s.hi_on  = !ce_odd_n;
        // a byte access through the low lane alone picks by address bit 0
        s.lo_odd = !ce_even_n && ce_odd_n && a0;
        return s;
    endfunction

    function automatic logic [1:0] byte_enables(input lane_sel_t s);
        logic [1:0] be;
        be[0] = s.lo_on && !s.lo_odd;
        be[1] = s.hi_on || (s.lo_on && s.lo_odd);
        return be;
    endfunction

    function automatic word_t steer_write(input lane_sel_t s,
                                          input logic [2*BYTE_W-1:0] d);
        word_t w;
        w.even = d[BYTE_W-1:0];
        w.odd  = s.lo_odd ? d[BYTE_W-1:0] : d[2*BYTE_W-1:BYTE_W];
        return w;
    endfunction

    function automatic logic [2*BYTE_W-1:0] steer_read(input lane_sel_t s,
                                                       input word_t w);
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        lo = '0;
        hi = '0;
        if (s.lo_on) lo = s.lo_odd ? w.odd : w.even;
        if (s.hi_on) hi = w.odd;
        return {hi, lo};
    endfunction

endpackage

// File: rtl/mcard_wr_capture.sv
module mcard_wr_capture
    import mcard_pkg::*;
#(
    parameter int WA_W = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we_n,
    input  logic                  attr,
    input  lane_sel_t             sel,
    input  logic [WA_W-1:0]       wa,
    input  logic [2*BYTE_W-1:0]   wdata,
    output logic                  commit,
    output logic                  held_attr,
    output logic [WA_W-1:0]       held_wa,
    output logic [1:0]            held_be,
    output word_t                 held_word
);

    logic held_valid;
    logic active;

    assign active = !we_n && (sel.lo_on || sel.hi_on);
    assign commit = held_valid && we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_valid <= 1'b0;
            held_attr  <= 1'b0;
            held_wa    <= '0;
            held_be    <= '0;
            held_word  <= '0;
        end else begin
            held_valid <= active;
            if (active) begin
                held_attr <= attr;
                held_wa   <= wa;
                held_be   <= byte_enables(sel);
                held_word <= steer_write(sel, wdata);
            end
        end
    end

endmodule

// File: rtl/mcard_attr_store.sv
module mcard_attr_store
    import mcard_pkg::*;
#(
    parameter int WA_W      = 10,
    parameter int CIS_BYTES = 256,
    parameter int CFG_BASE  = 'h200,
    parameter int CFG_N     = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WA_W-1:0]    rd_wa,
    output logic [BYTE_W-1:0]  rd_byte,
    input  logic               wr_en,
    input  logic [WA_W-1:0]    wr_wa,
    input  logic [BYTE_W-1:0]  wr_byte
);

    localparam int CIS_IDX_W = $clog2(CIS_BYTES);
    localparam int CFG_IDX_W = (CFG_N > 1) ? $clog2(CFG_N) : 1;
    localparam logic [WA_W-1:0] CIS_LIM = WA_W'(CIS_BYTES);
    localparam logic [WA_W-1:0] CFG_LO  = WA_W'(CFG_BASE / 2);
    localparam logic [WA_W-1:0] CFG_HI  = WA_W'(CFG_BASE / 2 + CFG_N);

    logic [BYTE_W-1:0] cis_mem [CIS_BYTES];
    logic [CFG_N-1:0][BYTE_W-1:0] cfg_bus;

    logic               rd_cis, rd_cfg, wr_cis, wr_cfg;
    logic [WA_W-1:0]    rd_off, wr_off;
    logic [CFG_IDX_W-1:0] rd_cidx, wr_cidx;

    assign rd_cis  = rd_wa < CIS_LIM;
    assign rd_cfg  = (rd_wa >= CFG_LO) && (rd_wa < CFG_HI);
    assign wr_cis  = wr_wa < CIS_LIM;
    assign wr_cfg  = (wr_wa >= CFG_LO) && (wr_wa < CFG_HI);
    assign rd_off  = rd_wa - CFG_LO;
    assign wr_off  = wr_wa - CFG_LO;
    assign rd_cidx = rd_off[CFG_IDX_W-1:0];
    assign wr_cidx = wr_off[CFG_IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CIS_BYTES; i++) cis_mem[i] <= '0;
        end else if (wr_en && wr_cis) begin
            cis_mem[wr_wa[CIS_IDX_W-1:0]] <= wr_byte;
        end
    end

    for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else if (wr_en && wr_cfg && (wr_cidx == CFG_IDX_W'(g))) q <= wr_byte;
        end
        assign cfg_bus[g] = q;
    end

    always_comb begin
        if (rd_cis)      rd_byte = cis_mem[rd_wa[CIS_IDX_W-1:0]];
        else if (rd_cfg) rd_byte = cfg_bus[rd_cidx];
        else             rd_byte = '0;
    end

endmodule

// File: rtl/mcard_read_mux.sv
module mcard_read_mux
    import mcard_pkg::*;
(
    input  logic                 oe_n,
    input  logic                 attr,
    input  lane_sel_t            sel,
    input  logic [2*BYTE_W-1:0]  cm_word,
    input  logic [BYTE_W-1:0]    attr_byte,
    output logic [2*BYTE_W-1:0]  rdata,
    output logic                 drive_lo,
    output logic                 drive_hi,
    output logic                 cm_rd
);

    logic  rd_act;
    word_t src;

    assign rd_act   = !oe_n && (sel.lo_on || sel.hi_on);
    assign drive_lo = rd_act && sel.lo_on;
    assign drive_hi = rd_act && sel.hi_on;
    assign cm_rd    = rd_act && !attr;

    always_comb begin
        if (attr) begin
            src.even = attr_byte;
            src.odd  = '0;
        end else begin
            src = cm_word;
        end
        rdata = rd_act ? steer_read(sel, src) : '0;
    end

endmodule

// File: rtl/mcard_lane_dec.sv
module mcard_lane_dec
    import mcard_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int CIS_BYTES = 256,
    parameter int CFG_BASE  = 'h200,
    parameter int CFG_N     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic                 host_ce_even_n,
    input  logic                 host_ce_odd_n,
    input  logic                 host_regsel_n,
    input  logic                 host_oe_n,
    input  logic                 host_we_n,
    input  logic [15:0]          host_wdata,
    output logic [15:0]          host_rdata,
    output logic                 host_drive_lo,
    output logic                 host_drive_hi,
    output logic [ADDR_W-2:0]    cm_raddr,
    output logic                 cm_rd,
    input  logic [15:0]          cm_rdata,
    output logic                 cm_wr,
    output logic [ADDR_W-2:0]    cm_waddr,
    output logic [1:0]           cm_wbe,
    output logic [15:0]          cm_wdata
);

    localparam int WA_W = ADDR_W - 1;

    lane_sel_t         sel;
    logic              attr;
    logic [WA_W-1:0]   wa;
    logic              commit, held_attr;
    logic [WA_W-1:0]   held_wa;
    logic [1:0]        held_be;
    word_t             held_word;
    logic [BYTE_W-1:0] attr_byte;

    assign sel      = lane_decode(host_ce_even_n, host_ce_odd_n, host_addr[0]);
    assign attr     = !host_regsel_n;
    assign wa       = host_addr[ADDR_W-1:1];
    assign cm_raddr = wa;

    mcard_wr_capture #(.WA_W(WA_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .we_n      (host_we_n),
        .attr      (attr),
        .sel       (sel),
        .wa        (wa),
        .wdata     (host_wdata),
        .commit    (commit),
        .held_attr (held_attr),
        .held_wa   (held_wa),
        .held_be   (held_be),
        .held_word (held_word)
    );

    mcard_attr_store #(
        .WA_W      (WA_W),
        .CIS_BYTES (CIS_BYTES),
        .CFG_BASE  (CFG_BASE),
        .CFG_N     (CFG_N)
    ) u_attr (
        .clk     (clk),
        .rst     (rst),
        .rd_wa   (wa),
        .rd_byte (attr_byte),
        .wr_en   (commit && held_attr && held_be[0]),
        .wr_wa   (held_wa),
        .wr_byte (held_word.even)
    );

    mcard_read_mux u_rd (
        .oe_n      (host_oe_n),
        .attr      (attr),
        .sel       (sel),
        .cm_word   (cm_rdata),
        .attr_byte (attr_byte),
        .rdata     (host_rdata),
        .drive_lo  (host_drive_lo),
        .drive_hi  (host_drive_hi),
        .cm_rd     (cm_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cm_wr    <= 1'b0;
            cm_waddr <= '0;
            cm_wbe   <= '0;
            cm_wdata <= '0;
        end else begin
            cm_wr <= commit && !held_attr && (held_be != 2'b00);
            if (commit && !held_attr) begin
                cm_waddr <= held_wa;
                cm_wbe   <= held_be;
                cm_wdata <= held_word;
            end
        end
    end

endmodule

// File: rtl/mcard_lane_dec_chk.sv
module mcard_lane_dec_chk (
    input logic clk,
    input logic rst,
    input logic host_ce_even_n,
    input logic host_ce_odd_n,
    input logic host_regsel_n,
    input logic host_oe_n,
    input logic host_we_n,
    input logic host_drive_lo,
    input logic host_drive_hi,
    input logic cm_wr
);

    a_r6_no_drive_idle: assert property (@(posedge clk) disable iff (rst)
        (host_oe_n || (host_ce_even_n && host_ce_odd_n)) |-> (!host_drive_lo && !host_drive_hi));

    a_r4_hi_lane_only: assert property (@(posedge clk) disable iff (rst)
        (!host_oe_n && host_ce_even_n && !host_ce_odd_n) |-> (host_drive_hi && !host_drive_lo));

    a_r5_word_both_lanes: assert property (@(posedge clk) disable iff (rst)
        (!host_oe_n && !host_ce_even_n && !host_ce_odd_n) |-> (host_drive_hi && host_drive_lo));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cm_wr |=> !cm_wr);

    a_r8_after_trailing_edge: assert property (@(posedge clk) disable iff (rst)
        cm_wr |-> ($past(host_we_n, 1) && !$past(host_we_n, 2)));

    a_r11_attr_no_cm_write: assert property (@(posedge clk) disable iff (rst)
        cm_wr |-> $past(host_regsel_n, 2));

endmodule

bind mcard_lane_dec mcard_lane_dec_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .host_ce_even_n (host_ce_even_n),
    .host_ce_odd_n  (host_ce_odd_n),
    .host_regsel_n  (host_regsel_n),
    .host_oe_n      (host_oe_n),
    .host_we_n      (host_we_n),
    .host_drive_lo  (host_drive_lo),
    .host_drive_hi  (host_drive_hi),
    .cm_wr          (cm_wr)
);

// File: tb/mcard_lane_dec_tb.sv
module mcard_lane_dec_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {ce_even_n, ce_odd_n, addr[10:0]}
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 11'h010},
        {1'b0, 1'b1, 11'h011},
        {1'b1, 1'b0, 11'h010},
        {1'b0, 1'b0, 11'h022},
        {1'b1, 1'b1, 11'h022},
        {1'b0, 1'b1, 11'h7FF},
        {1'b0, 1'b0, 11'h7FE},
        {1'b1, 1'b0, 11'h333}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] host_addr = '0;
    logic        host_ce_even_n = 1'b1, host_ce_odd_n = 1'b1;
    logic        host_regsel_n = 1'b1, host_oe_n = 1'b1, host_we_n = 1'b1;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata, cm_rdata, cm_wdata;
    logic        host_drive_lo, host_drive_hi, cm_rd, cm_wr;
    logic [9:0]  cm_raddr, cm_waddr;
    logic [1:0]  cm_wbe;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cm_rdata = {cm_raddr[7:0] ^ 8'h5A, cm_raddr[7:0]};

    mcard_lane_dec u_dut (
        .clk(clk), .rst(rst), .host_addr(host_addr),
        .host_ce_even_n(host_ce_even_n), .host_ce_odd_n(host_ce_odd_n),
        .host_regsel_n(host_regsel_n), .host_oe_n(host_oe_n), .host_we_n(host_we_n),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_drive_lo(host_drive_lo), .host_drive_hi(host_drive_hi),
        .cm_raddr(cm_raddr), .cm_rd(cm_rd), .cm_rdata(cm_rdata),
        .cm_wr(cm_wr), .cm_waddr(cm_waddr), .cm_wbe(cm_wbe), .cm_wdata(cm_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_start(input logic ce_e, input logic ce_o, input logic regn,
                            input logic [10:0] a);
        @(negedge clk);
        host_ce_even_n = ce_e;
        host_ce_odd_n  = ce_o;
        host_regsel_n  = regn;
        host_addr      = a;
        host_oe_n      = 1'b0;
        #1;
    endtask

    task automatic bus_idle();
        host_oe_n = 1'b1;
        host_ce_even_n = 1'b1;
        host_ce_odd_n = 1'b1;
        host_regsel_n = 1'b1;
    endtask

    // returns with the cycle after the commit edge visible
    task automatic wr(input logic ce_e, input logic ce_o, input logic regn,
                      input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        host_ce_even_n = ce_e;
        host_ce_odd_n  = ce_o;
        host_regsel_n  = regn;
        host_addr      = a;
        host_wdata     = d;
        host_we_n      = 1'b0;
        @(negedge clk);
        host_we_n = 1'b1;
        bus_idle();
        host_wdata = '0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0]  ev, od;
        logic [15:0] exp_d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 drive_lo", {31'b0, host_drive_lo}, 0);
        chk("R1 drive_hi", {31'b0, host_drive_hi}, 0);
        chk("R1 rdata", {16'b0, host_rdata}, 0);
        chk("R1 cm_wr", {31'b0, cm_wr}, 0);
        for (int k = 0; k < 4; k++) begin
            rd_start(1'b0, 1'b1, 1'b0, 11'(11'h200 + 2 * k));
            chk("R1 cfg reset", {16'b0, host_rdata}, 0);
            bus_idle();
        end

        // table of common-memory reads: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            logic ce_e, ce_o, el, eh;
            logic [10:0] a;
            ce_e = VEC[i][12];
            ce_o = VEC[i][11];
            a    = VEC[i][10:0];
            ev   = a[8:1];
            od   = ev ^ 8'h5A;
            el   = !ce_e;
            eh   = !ce_o;
            exp_d = '0;
            if (el) exp_d[7:0] = (ce_o && a[0]) ? od : ev;
            if (eh) exp_d[15:8] = od;
            rd_start(ce_e, ce_o, 1'b1, a);
            chk("R2/R3/R4/R5/R6 rdata", {16'b0, host_rdata}, {16'b0, exp_d});
            chk("R6 drive_lo", {31'b0, host_drive_lo}, {31'b0, el});
            chk("R6 drive_hi", {31'b0, host_drive_hi}, {31'b0, eh});
            chk("R7 cm_rd", {31'b0, cm_rd}, {31'b0, (el | eh)});
            chk("R7 cm_raddr", {22'b0, cm_raddr}, {22'b0, a[10:1]});
            bus_idle();
        end

        // R6 read strobe high with word enables
        @(negedge clk);
        host_ce_even_n = 1'b0; host_ce_odd_n = 1'b0; host_addr = 11'h010;
        #1;
        chk("R6 oe high no drive", {30'b0, host_drive_hi, host_drive_lo}, 0);
        chk("R6 oe high zero data", {16'b0, host_rdata}, 0);
        bus_idle();

        // R8 word write
        wr(1'b0, 1'b0, 1'b1, 11'h040, 16'hBEEF);
        chk("R8 cm_wr pulse", {31'b0, cm_wr}, 1);
        chk("R8 word be", {30'b0, cm_wbe}, 2'b11);
        chk("R8 word addr", {22'b0, cm_waddr}, 10'h020);
        chk("R8 word data", {16'b0, cm_wdata}, 16'hBEEF);
        @(negedge clk);
        chk("R8 pulse one cycle", {31'b0, cm_wr}, 0);

        // R8 odd byte through low lane
        wr(1'b0, 1'b1, 1'b1, 11'h041, 16'h0077);
        chk("R8 low-lane odd be", {30'b0, cm_wbe}, 2'b10);
        chk("R8 low-lane odd data", {24'b0, cm_wdata[15:8]}, 8'h77);
        // R8 even byte through low lane
        wr(1'b0, 1'b1, 1'b1, 11'h042, 16'h0033);
        chk("R8 even be", {30'b0, cm_wbe}, 2'b01);
        chk("R8 even data", {24'b0, cm_wdata[7:0]}, 8'h33);
        // R8 odd byte on high lane
        wr(1'b1, 1'b0, 1'b1, 11'h044, 16'h9900);
        chk("R8 high-lane be", {30'b0, cm_wbe}, 2'b10);
        chk("R8 high-lane data", {24'b0, cm_wdata[15:8]}, 8'h99);
        chk("R8 high-lane addr", {22'b0, cm_waddr}, 10'h022);

        // R9 R11 attribute byte
        wr(1'b0, 1'b1, 1'b0, 11'h004, 16'h003C);
        chk("R11 no cm_wr on attr", {31'b0, cm_wr}, 0);
        rd_start(1'b0, 1'b1, 1'b0, 11'h004);
        chk("R9 attr readback", {16'b0, host_rdata}, 16'h003C);
        chk("R7 attr cm_rd low", {31'b0, cm_rd}, 0);
        bus_idle();
        wr(1'b0, 1'b1, 1'b0, 11'h005, 16'h00FF);
        chk("R11 odd attr no cm_wr", {31'b0, cm_wr}, 0);
        rd_start(1'b0, 1'b1, 1'b0, 11'h005);
        chk("R9 odd attr reads zero", {16'b0, host_rdata}, 0);
        bus_idle();
        rd_start(1'b0, 1'b0, 1'b0, 11'h004);
        chk("R9 odd write left even intact", {16'b0, host_rdata}, 16'h003C);
        bus_idle();

        // R10 configuration bytes
        wr(1'b0, 1'b1, 1'b0, 11'h202, 16'h0081);
        rd_start(1'b0, 1'b1, 1'b0, 11'h202);
        chk("R10 cfg write", {16'b0, host_rdata}, 16'h0081);
        bus_idle();
        rd_start(1'b0, 1'b1, 1'b0, 11'h200);
        chk("R10 neighbour cfg untouched", {16'b0, host_rdata}, 0);
        bus_idle();
        wr(1'b0, 1'b1, 1'b0, 11'h3F0, 16'h0055);
        rd_start(1'b0, 1'b1, 1'b0, 11'h3F0);
        chk("R10 beyond cfg reads zero", {16'b0, host_rdata}, 0);
        bus_idle();
        rd_start(1'b0, 1'b1, 1'b0, 11'h202);
        chk("R10 cfg kept", {16'b0, host_rdata}, 16'h0081);
        bus_idle();

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule